// File: doc/BRIEF.md
# Three-Phase Bang-Bang Current Regulator

This block closes a current loop for a three-leg inverter without a carrier. For each leg it compares a signed sampled load current against a signed current set-point. The upper switch is commanded whenever the current has dropped too far below the set-point, and the lower switch whenever it has climbed too far above it. While the error stays inside a programmable tolerance window, the leg keeps its present state. Switching therefore follows band crossings alone, and the switching frequency is not fixed in advance.

Each leg drives a complementary gate pair. A programmable both-off gap is inserted on every change of side, and a programmable minimum conduction time stops chattering. A per-leg 32-bit counter counts accepted side changes. Because the three load currents sum to zero, an optional mode regulates only legs a and b. In that mode leg c works from a derived current and a derived set-point, each equal to minus the sum of the other two, and the leg c inputs are not used.

Configuration (`band`, `dead_cfg`, `min_on_cfg`, `derive_c`) is expected to be stable while `rst` is low.

Top module: `hcc_top`

## Requirements
- R1: While `rst` is high at a clock edge, and afterwards until the first edge with `smp_valid` high, every gate output is 0 and every transition counter is 0.
- R2: At the first edge with `smp_valid` high after reset, each leg turns on one side, visible in the next cycle. The upper gate (`gate_hi`) turns on if the current is strictly below the set-point. Otherwise the lower gate (`gate_lo`) turns on. This first turn-on is not counted.
- R3: Once a leg is conducting, a sample requests the upper side when current < set-point − (band>>1). It requests the lower side when current > set-point + (band>>1). A current equal to either limit, or between them, keeps the present side. `band` is unsigned; current and set-point are two's complement.
- R4: `gate_hi[p]` and `gate_lo[p]` are never both 1. Bit p is leg a for 0, leg b for 1 and leg c for 2.
- R5: An accepted request for the opposite side turns both gates of the leg off for exactly `dead_cfg` cycles, then turns on the new side. With `dead_cfg` = 0 the sides swap in one edge with no gap.
- R6: A request for the opposite side is dropped unless at least `min_on_cfg` clocks have passed since the present side turned on. The timer counts edges while conducting and saturates at its maximum value.
- R7: Inputs are looked at only on edges with `smp_valid` high. Samples that arrive during a both-off gap are dropped.
- R8: A leg's transition counter goes up by exactly 1 for each accepted side change and never changes otherwise.
- R9: With `derive_c` = 1, leg c uses −(meas_a+meas_b) as its current and −(ref_a+ref_b) as its set-point, computed without overflow. `meas_c` and `ref_c` then have no effect.
- R10: The three legs behave identically and independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe for all current and set-point inputs |
| derive_c | input | 1 | 1: leg c uses quantities derived from legs a and b |
| band | input | 16 | Unsigned tolerance band; half of it is used on each side |
| dead_cfg | input | 8 | Both-off gap length in clocks |
| min_on_cfg | input | 16 | Minimum conduction time in clocks |
| meas_a | input | 16 | Leg a sampled current, signed |
| ref_a | input | 16 | Leg a set-point, signed |
| meas_b | input | 16 | Leg b sampled current, signed |
| ref_b | input | 16 | Leg b set-point, signed |
| meas_c | input | 16 | Leg c sampled current, signed |
| ref_c | input | 16 | Leg c set-point, signed |
| gate_hi | output | 3 | Upper switch commands, bit 0 = leg a |
| gate_lo | output | 3 | Lower switch commands, bit 0 = leg a |
| sw_cnt_a | output | 32 | Leg a accepted side changes |
| sw_cnt_b | output | 32 | Leg b accepted side changes |
| sw_cnt_c | output | 32 | Leg c accepted side changes |

## Verification
The hardest case to reach is a sample landing inside the both-off gap or inside the minimum conduction window with an opposite-side request. Such a sample must be dropped, and a strobe one cycle later must not be. The stimulus reaches it by strobing `smp_valid` on every cycle while the current swings across the whole band. A long minimum-on setting makes most requests fall inside the window. Exact limit values (−half and +half) and derived leg c sums near full scale, including a wild `meas_c`, test the comparison edges and the overflow-free derivation.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
    typedef enum logic [1:0] {
        LEG_IDLE = 2'd0,
        LEG_ON   = 2'd1,
        LEG_DEAD = 2'd2
    } leg_st_e;
endpackage

// File: rtl/hcc_input_map.sv
module hcc_input_map #(
    parameter int DW  = 16,
    parameter int NPH = 3,
    localparam int EW = DW + 2
) (
    input  logic                 derive_c,
    input  logic signed [DW-1:0] meas_a,
    input  logic signed [DW-1:0] ref_a,
    input  logic signed [DW-1:0] meas_b,
    input  logic signed [DW-1:0] ref_b,
    input  logic signed [DW-1:0] meas_c,
    input  logic signed [DW-1:0] ref_c,
    output logic signed [EW-1:0] meas_e [NPH],
    output logic signed [EW-1:0] ref_e  [NPH]
);
    logic signed [EW-1:0] ma_x, mb_x, mc_x, ra_x, rb_x, rc_x;

    always_comb begin
        ma_x = {{(EW-DW){meas_a[DW-1]}}, meas_a};
        mb_x = {{(EW-DW){meas_b[DW-1]}}, meas_b};
        mc_x = {{(EW-DW){meas_c[DW-1]}}, meas_c};
        ra_x = {{(EW-DW){ref_a[DW-1]}}, ref_a};
        rb_x = {{(EW-DW){ref_b[DW-1]}}, ref_b};
        rc_x = {{(EW-DW){ref_c[DW-1]}}, ref_c};
        for (int p = 0; p < NPH; p++) begin
            meas_e[p] = '0;
            ref_e[p]  = '0;
        end
        meas_e[0] = ma_x;
        ref_e[0]  = ra_x;
        meas_e[1] = mb_x;
        ref_e[1]  = rb_x;
        // the three load currents sum to zero, so leg c can be inferred
        meas_e[2] = derive_c ? -(ma_x + mb_x) : mc_x;
        ref_e[2]  = derive_c ? -(ra_x + rb_x) : rc_x;
    end
endmodule

// File: rtl/hcc_band_cmp.sv
module hcc_band_cmp #(
    parameter int DW  = 16,
    parameter int EW  = DW + 2,
    localparam int XW = EW + 1
) (
    input  logic signed [EW-1:0] meas,
    input  logic signed [EW-1:0] setp,
    input  logic        [DW-1:0] band,
    output logic                 want_hi,
    output logic                 want_lo,
    output logic                 below_setp
);
    logic signed [XW-1:0] m_x, r_x, h_x;

    always_comb begin
        m_x = {{(XW-EW){meas[EW-1]}}, meas};
        r_x = {{(XW-EW){setp[EW-1]}}, setp};
        h_x = {{(XW-DW+1){1'b0}}, band[DW-1:1]};
        want_hi    = m_x < (r_x - h_x);
        want_lo    = m_x > (r_x + h_x);
        below_setp = m_x < r_x;
    end
endmodule

// File: rtl/hcc_leg.sv
module hcc_leg
    import hcc_pkg::*;
#(
    parameter int DTW = 8,
    parameter int MOW = 16,
    parameter int CW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid,
    input  logic           want_hi,
    input  logic           want_lo,
    input  logic           below_setp,
    input  logic [DTW-1:0] dead_cfg,
    input  logic [MOW-1:0] min_on_cfg,
    output logic           gate_hi,
    output logic           gate_lo,
    output logic [CW-1:0]  sw_cnt
);
    typedef struct packed {
        leg_st_e        st;
        logic           hi_side;
        logic [DTW-1:0] dcnt;
        logic [MOW-1:0] ton;
        logic [CW-1:0]  cnt;
    } leg_t;

    leg_t leg_d, leg_q;
    logic flip_req;

    always_comb begin
        leg_d    = leg_q;
        flip_req = leg_q.hi_side ? want_lo : want_hi;
        case (leg_q.st)
            LEG_IDLE: begin
                if (valid) begin
                    leg_d.st      = LEG_ON;
                    leg_d.hi_side = below_setp;
                    leg_d.ton     = '0;
                end
            end
            LEG_ON: begin
                if (leg_q.ton != {MOW{1'b1}}) leg_d.ton = leg_q.ton + 1'b1;
                if (valid && flip_req && (leg_q.ton >= min_on_cfg)) begin
                    leg_d.hi_side = ~leg_q.hi_side;
                    leg_d.cnt     = leg_q.cnt + 1'b1;
                    leg_d.ton     = '0;
                    if (dead_cfg == '0) begin
                        leg_d.st = LEG_ON;
                    end else begin
                        leg_d.st   = LEG_DEAD;
                        leg_d.dcnt = dead_cfg;
                    end
                end
            end
            LEG_DEAD: begin
                if (leg_q.dcnt <= 1) begin
                    leg_d.st  = LEG_ON;
                    leg_d.ton = '0;
                end else begin
                    leg_d.dcnt = leg_q.dcnt - 1'b1;
                end
            end
            default: leg_d.st = LEG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            leg_q <= '{st: LEG_IDLE, hi_side: 1'b0, dcnt: '0, ton: '0, cnt: '0};
        end else begin
            leg_q <= leg_d;
        end
    end

    always_comb begin
        gate_hi = (leg_q.st == LEG_ON) &&  leg_q.hi_side;
        gate_lo = (leg_q.st == LEG_ON) && !leg_q.hi_side;
        sw_cnt  = leg_q.cnt;
    end

    p_pair_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    p_gap_hi_lo_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(gate_hi) && gate_lo) |-> ($past(dead_cfg) == '0));

    p_gap_lo_hi_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(gate_lo) && gate_hi) |-> ($past(dead_cfg) == '0));

    p_min_on_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sw_cnt) |-> ($past(leg_q.ton) >= $past(min_on_cfg)));

    p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sw_cnt) |-> (sw_cnt == $past(sw_cnt) + 1'b1));

    p_wait_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(leg_q.st) == LEG_IDLE && !$past(valid)) |-> (leg_q.st == LEG_IDLE));
endmodule

// File: rtl/hcc_top.sv
module hcc_top #(
    parameter int DW  = 16,
    parameter int DTW = 8,
    parameter int MOW = 16,
    parameter int CW  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_valid,
    input  logic                 derive_c,
    input  logic        [DW-1:0] band,
    input  logic       [DTW-1:0] dead_cfg,
    input  logic       [MOW-1:0] min_on_cfg,
    input  logic signed [DW-1:0] meas_a,
    input  logic signed [DW-1:0] ref_a,
    input  logic signed [DW-1:0] meas_b,
    input  logic signed [DW-1:0] ref_b,
    input  logic signed [DW-1:0] meas_c,
    input  logic signed [DW-1:0] ref_c,
    output logic           [2:0] gate_hi,
    output logic           [2:0] gate_lo,
    output logic        [CW-1:0] sw_cnt_a,
    output logic        [CW-1:0] sw_cnt_b,
    output logic        [CW-1:0] sw_cnt_c
);
    localparam int NPH = 3;
    localparam int EW  = DW + 2;

    logic signed [EW-1:0] meas_e [NPH];
    logic signed [EW-1:0] ref_e  [NPH];
    logic [NPH-1:0] want_hi, want_lo, below;
    logic [CW-1:0]  cnt_v [NPH];

    hcc_input_map #(.DW(DW), .NPH(NPH)) u_map (
        .derive_c (derive_c),
        .meas_a   (meas_a),
        .ref_a    (ref_a),
        .meas_b   (meas_b),
        .ref_b    (ref_b),
        .meas_c   (meas_c),
        .ref_c    (ref_c),
        .meas_e   (meas_e),
        .ref_e    (ref_e)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        hcc_band_cmp #(.DW(DW), .EW(EW)) u_cmp (
            .meas       (meas_e[p]),
            .setp       (ref_e[p]),
            .band       (band),
            .want_hi    (want_hi[p]),
            .want_lo    (want_lo[p]),
            .below_setp (below[p])
        );

        hcc_leg #(.DTW(DTW), .MOW(MOW), .CW(CW)) u_leg (
            .clk        (clk),
            .rst        (rst),
            .valid      (smp_valid),
            .want_hi    (want_hi[p]),
            .want_lo    (want_lo[p]),
            .below_setp (below[p]),
            .dead_cfg   (dead_cfg),
            .min_on_cfg (min_on_cfg),
            .gate_hi    (gate_hi[p]),
            .gate_lo    (gate_lo[p]),
            .sw_cnt     (cnt_v[p])
        );
    end

    always_comb begin
        sw_cnt_a = cnt_v[0];
        sw_cnt_b = cnt_v[1];
        sw_cnt_c = cnt_v[2];
    end

    // a side can only be requested from outside the band, never both at once
    p_req_excl_r3: assert property (@(posedge clk) disable iff (rst)
        (want_hi & want_lo) == '0);
endmodule

// File: tb/tb_hcc_top.sv
module tb_hcc_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic derive_c = 1'b0;
    logic [15:0] band = '0;
    logic [7:0]  dead_cfg = '0;
    logic [15:0] min_on_cfg = '0;
    logic signed [15:0] meas_a = '0, ref_a = '0, meas_b = '0, ref_b = '0, meas_c = '0, ref_c = '0;
    logic [2:0] gate_hi, gate_lo;
    logic [31:0] sw_cnt_a, sw_cnt_b, sw_cnt_c;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    string cur_req = "R1";

    // behavioural reference state: 0 idle, 1 conducting, 2 gap
    int m_st [3];
    int m_hi [3];
    int m_ton[3];
    int m_dc [3];
    longint m_cnt[3];

    always #2 clk = ~clk;

    hcc_top dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .derive_c(derive_c),
        .band(band), .dead_cfg(dead_cfg), .min_on_cfg(min_on_cfg),
        .meas_a(meas_a), .ref_a(ref_a), .meas_b(meas_b), .ref_b(ref_b),
        .meas_c(meas_c), .ref_c(ref_c),
        .gate_hi(gate_hi), .gate_lo(gate_lo),
        .sw_cnt_a(sw_cnt_a), .sw_cnt_b(sw_cnt_b), .sw_cnt_c(sw_cnt_c)
    );

    always @(posedge clk) begin
        int m, r, h;
        bit up, dn;
        for (int p = 0; p < 3; p++) begin
            if (rst) begin
                m_st[p] = 0; m_hi[p] = 0; m_ton[p] = 0; m_dc[p] = 0; m_cnt[p] = 0;
            end else begin
                if (p == 0) begin m = meas_a; r = ref_a; end
                else if (p == 1) begin m = meas_b; r = ref_b; end
                else if (derive_c) begin m = -(int'(meas_a) + int'(meas_b)); r = -(int'(ref_a) + int'(ref_b)); end
                else begin m = meas_c; r = ref_c; end
                h  = int'(band) / 2;
                up = (m < r - h);
                dn = (m > r + h);
                if (m_st[p] == 0) begin
                    if (smp_valid) begin m_st[p] = 1; m_hi[p] = (m < r); m_ton[p] = 0; end
                end else if (m_st[p] == 1) begin
                    if (smp_valid && (m_hi[p] == 1 ? dn : up) && m_ton[p] >= int'(min_on_cfg)) begin
                        m_hi[p] = 1 - m_hi[p];
                        m_cnt[p] = (m_cnt[p] + 1) % 64'h1_0000_0000;
                        m_ton[p] = 0;
                        if (dead_cfg == 0) m_st[p] = 1;
                        else begin m_st[p] = 2; m_dc[p] = dead_cfg; end
                    end else if (m_ton[p] < 65535) begin
                        m_ton[p]++;
                    end
                end else begin
                    if (m_dc[p] <= 1) begin m_st[p] = 1; m_ton[p] = 0; end
                    else m_dc[p]--;
                end
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        logic [31:0] cv;
        bit eh, el;
        for (int p = 0; p < 3; p++) begin
            eh = (m_st[p] == 1) && (m_hi[p] == 1);
            el = (m_st[p] == 1) && (m_hi[p] == 0);
            n_chk++;
            if (gate_hi[p] !== eh || gate_lo[p] !== el) begin
                n_err++;
                $display("FAIL %s leg %0d cyc %0d: hi/lo=%b%b expected %b%b",
                         cur_req, p, cyc, gate_hi[p], gate_lo[p], eh, el);
            end
            n_chk++;
            if (gate_hi[p] === 1'b1 && gate_lo[p] === 1'b1) begin
                n_err++;
                $display("FAIL R4 leg %0d: both gates on, actual 11 expected not 11", p);
            end
            cv = (p == 0) ? sw_cnt_a : (p == 1) ? sw_cnt_b : sw_cnt_c;
            n_chk++;
            if (cv !== 32'(m_cnt[p])) begin
                n_err++;
                $display("FAIL R8 (%s) leg %0d: count=%0d expected %0d", cur_req, p, cv, m_cnt[p]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(int b, int d, int mo, bit der);
        @(negedge clk); #1;
        rst = 1'b1; smp_valid = 1'b0;
        band = 16'(b); dead_cfg = 8'(d); min_on_cfg = 16'(mo); derive_c = der;
        idle(2); #1;
        rst = 1'b0;
    endtask

    task automatic smp(int ma, int ra, int mb, int rb, int mc, int rc, int gap);
        @(negedge clk); #1;
        meas_a = 16'(ma); ref_a = 16'(ra); meas_b = 16'(mb); ref_b = 16'(rb);
        meas_c = 16'(mc); ref_c = 16'(rc);
        smp_valid = 1'b1;
        @(negedge clk); #1;
        smp_valid = 1'b0;
        if (gap > 0) idle(gap);
    endtask

    initial begin
        // R1: reset state and waiting for first strobe with moving inputs
        cur_req = "R1";
        start(100, 3, 0, 0);
        meas_a = 16'sd500; meas_b = -16'sd500;
        idle(6);
        // R2: first turn-on side from sign of error, c equal -> lower
        cur_req = "R2";
        smp(-10, 0, 10, 0, 7, 7, 4);
        // R3: limits with half band 50
        cur_req = "R3";
        smp(50, 0, -50, 0, 0, 0, 3);
        smp(51, 0, -51, 0, 0, 0, 6);
        smp(-50, 0, 50, 0, 49, 0, 3);
        smp(-51, 0, 51, 0, 51, 0, 6);
        smp(200, 300, -300, -200, -51, 0, 6);
        // R5: zero gap swaps immediately
        cur_req = "R5";
        start(20, 0, 0, 0);
        smp(-100, 0, 100, 0, 0, 0, 2);
        smp(100, 0, -100, 0, 100, 0, 2);
        smp(-100, 0, 100, 0, -100, 0, 2);
        start(20, 7, 0, 0);
        smp(-100, 0, 100, 0, 0, 0, 2);
        smp(100, 0, -100, 0, 100, 0, 10);
        // R7: strobes inside the gap are dropped
        cur_req = "R7";
        smp(-100, 0, 100, 0, -100, 0, 0);
        smp(100, 0, -100, 0, 100, 0, 0);
        smp(-100, 0, 100, 0, -100, 0, 10);
        // R6: long minimum conduction with requests every cycle
        cur_req = "R6";
        start(10, 2, 20, 0);
        smp(-100, 0, 100, 0, 0, 0, 0);
        for (int k = 0; k < 80; k++) begin
            @(negedge clk); #1;
            smp_valid = 1'b1;
            meas_a = (k % 2) ? 16'sd100 : -16'sd100;
            meas_b = ((k / 3) % 2) ? 16'sd100 : -16'sd100;
            meas_c = ((k / 5) % 2) ? 16'sd100 : -16'sd100;
        end
        @(negedge clk); #1; smp_valid = 1'b0;
        idle(5);
        // R9: derived third leg, wild meas_c, sums near full scale
        cur_req = "R9";
        start(64, 1, 0, 1);
        smp(-32768, 0, -32768, 0, 32767, -32768, 3);
        smp(32767, 0, 32767, 0, -32768, 32767, 3);
        smp(100, 0, 0, 0, 9000, 0, 3);
        smp(-40, 0, 0, 0, -9000, 0, 3);
        smp(0, 0, 0, 0, 32767, 32767, 3);
        // R10: random traffic on all legs, both modes
        cur_req = "R10";
        for (int mode = 0; mode < 2; mode++) begin
            start(40, 3, 4, mode[0]);
            for (int k = 0; k < 600; k++) begin
                @(negedge clk); #1;
                smp_valid = ($urandom_range(0, 2) != 0);
                meas_a = 16'(int'($urandom_range(0, 200)) - 100);
                meas_b = 16'(int'($urandom_range(0, 200)) - 100);
                meas_c = 16'(int'($urandom_range(0, 200)) - 100);
                ref_a  = 16'(int'($urandom_range(0, 40)) - 20);
                ref_b  = 16'(int'($urandom_range(0, 40)) - 20);
                ref_c  = 16'(int'($urandom_range(0, 40)) - 20);
            end
            @(negedge clk); #1; smp_valid = 1'b0;
            idle(5);
        end
        // activity must have produced transitions on every leg
        n_chk++;
        if (sw_cnt_a == 0 || sw_cnt_b == 0 || sw_cnt_c == 0) begin
            n_err++;
            $display("FAIL R8 activity: counts %0d %0d %0d expected all nonzero", sw_cnt_a, sw_cnt_b, sw_cnt_c);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule